// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

Two 8-bit up-counters, each with its own compare byte, count single-cycle enable ticks chosen from a small set of prescaler strobes. When a counter reaches its compare value, it sends out a one-cycle match pulse and restarts from zero. Each counter also sets a sticky interrupt flag. Timer 1 can instead count the match pulses of timer 0. This turns the pair into a two-stage divider.

A two-bit mode field fuses the pair into one 16-bit interval timer. Timer 0 then wraps freely and its carry clocks timer 1. The 16-bit compare value is timer 1's byte above timer 0's byte. A match is declared only when both bytes agree at the same step. All logic runs in one clock domain, and every count is qualified by an enable. No derived clocks are used.

Top module: `dual_interval_timer`

## Requirements
- R1: With `mode` not equal to 2'b01, each timer adds one per enable of its selected source. When the incremented value equals its compare byte, the timer returns to zero and its match output is high for exactly one cycle. A compare of N therefore gives a match every N source ticks.
- R2: The clock-select encodings are as follows. Values 0, 1 and 2 pick `pre_tick[0]`, `pre_tick[1]` and `pre_tick[2]`. Value 3 picks `ext_tick` for timer 0 and timer 0's match pulse for timer 1.
- R3: A compare byte of 0 in 8-bit operation gives a match every 256 source ticks.
- R4: With timer 1 select 3, compare bytes 5 and 2 and timer 0 ticking every cycle, `match1` pulses every 10 cycles. Each pulse appears in the cycle right after a `match0` pulse.
- R5: `mode` = 2'b01 selects 16-bit operation, and the values 00, 10 and 11 all select 8-bit operation. In 16-bit operation the interval is {`cmp1`,`cmp0`} ticks of timer 0's source, reported on `match1`.
- R6: In 16-bit operation, `t1_sel` has no effect on the interval and `match0` stays low.
- R7: While `run` is low, both counters hold zero and no match pulse appears. After `run` rises, the first match comes exactly compare-value ticks later.
- R8: `irq0`/`irq1` go high together with `match0`/`match1` and stay high until a one on the matching `irq_clr` bit clears them.
- R9: A new compare byte written while running governs the very next comparison.
- R10: After reset, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Count enable; low clears both counters |
| mode | input | 2 | 2'b01 = fused 16-bit timer, otherwise two 8-bit timers |
| t0_sel | input | 2 | Timer 0 source select |
| t1_sel | input | 2 | Timer 1 source select (unused in 16-bit mode) |
| pre_tick | input | 3 | Prescaler single-cycle enables |
| ext_tick | input | 1 | External count enable for timer 0 |
| cmp0 | input | 8 | Timer 0 compare byte (low byte in 16-bit mode) |
| cmp1 | input | 8 | Timer 1 compare byte (high byte in 16-bit mode) |
| irq_clr | input | 2 | Write-one-to-clear for irq0 (bit 0) and irq1 (bit 1) |
| match0 | output | 1 | Timer 0 match pulse |
| match1 | output | 1 | Timer 1 match pulse / 16-bit match pulse |
| irq0 | output | 1 | Sticky interrupt request of timer 0 |
| irq1 | output | 1 | Sticky interrupt request of timer 1 / 16-bit timer |

## Verification
The bench builds the block with its default parameters: 8-bit counters and three prescaler strobes, which gives 2-bit select fields. At this width the 256-tick wrap with a zero compare fits within a few hundred cycles. A 16-bit interval of 300 ticks also fits, and that interval forces a carry from the low byte into the high byte. Every select encoding can be driven, including the chained match source.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;

   typedef enum logic [1:0] {
      MODE_SPLIT   = 2'b00,
      MODE_FUSED   = 2'b01,
      MODE_SPLIT_B = 2'b10,
      MODE_SPLIT_C = 2'b11
   } dtmr_mode_e;

   function automatic logic is_fused(input logic [1:0] m);
      return m == MODE_FUSED;
   endfunction

endpackage

// File: rtl/dtmr_src_mux.sv
`timescale 1ns/1ps
module dtmr_src_mux #(
   parameter int N_SRC = 4,
   parameter int SEL_W = 2
) (
   input  logic [N_SRC-1:0] src,
   input  logic [SEL_W-1:0] sel,
   output logic             en
);

   if (N_SRC < 2) begin : g_bad_n
      $error("dtmr_src_mux: N_SRC must be at least 2");
   end
   if ((1 << SEL_W) < N_SRC) begin : g_bad_w
      $error("dtmr_src_mux: SEL_W too narrow for N_SRC");
   end

   always_comb begin
      en = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SEL_W'(i)) en = src[i];
      end
   end

endmodule

// File: rtl/dtmr_count_unit.sv
`timescale 1ns/1ps
module dtmr_count_unit #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         en,
   input  logic         hold_wrap,
   input  logic         clr_join,
   input  logic [W-1:0] cmp,
   output logic [W-1:0] cnt,
   output logic [W-1:0] nxt,
   output logic         hit,
   output logic         carry
);

   if (W < 2) begin : g_bad_w
      $error("dtmr_count_unit: W must be at least 2");
   end

   assign nxt   = cnt + 1'b1;
   assign hit   = run & en & (nxt == cmp);
   assign carry = run & en & (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || clr_join) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= (hit && !hold_wrap) ? '0 : nxt;
      end
   end

endmodule

// File: rtl/dtmr_irq_flag.sv
`timescale 1ns/1ps
module dtmr_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

endmodule

// File: rtl/dual_interval_timer.sv
`timescale 1ns/1ps
module dual_interval_timer
   import dtmr_pkg::*;
#(
   parameter  int CNT_W = 8,
   parameter  int N_PRE = 3,
   localparam int SEL_W = $clog2(N_PRE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       mode,
   input  logic [SEL_W-1:0] t0_sel,
   input  logic [SEL_W-1:0] t1_sel,
   input  logic [N_PRE-1:0] pre_tick,
   input  logic             ext_tick,
   input  logic [CNT_W-1:0] cmp0,
   input  logic [CNT_W-1:0] cmp1,
   input  logic [1:0]       irq_clr,
   output logic             match0,
   output logic             match1,
   output logic             irq0,
   output logic             irq1
);

   localparam int N_SRC = N_PRE + 1;

   if (N_PRE < 1) begin : g_bad_pre
      $error("dual_interval_timer: N_PRE must be at least 1");
   end

   logic             fused;
   logic             en0, en1_sel, en1;
   logic [CNT_W-1:0] cnt0, cnt1, nxt0, nxt1, hi_after;
   logic             hit0, hit1, carry0, carry1;
   logic             join_hit;
   logic [1:0]       ev;
   logic [1:0]       irq_q;

   assign fused = is_fused(mode);

   dtmr_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux0 (
      .src ({ext_tick, pre_tick}),
      .sel (t0_sel),
      .en  (en0)
   );

   dtmr_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux1 (
      .src ({match0, pre_tick}),
      .sel (t1_sel),
      .en  (en1_sel)
   );

   assign en1 = fused ? carry0 : en1_sel;

   dtmr_count_unit #(.W(CNT_W)) u_lo (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .en        (en0),
      .hold_wrap (fused),
      .clr_join  (join_hit),
      .cmp       (cmp0),
      .cnt       (cnt0),
      .nxt       (nxt0),
      .hit       (hit0),
      .carry     (carry0)
   );

   dtmr_count_unit #(.W(CNT_W)) u_hi (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .en        (en1),
      .hold_wrap (fused),
      .clr_join  (join_hit),
      .cmp       (cmp1),
      .cnt       (cnt1),
      .nxt       (nxt1),
      .hit       (hit1),
      .carry     (carry1)
   );

   // high byte as it will stand after this step
   assign hi_after = carry0 ? nxt1 : cnt1;
   assign join_hit = fused & hit0 & (hi_after == cmp1);

   assign ev[0] = ~fused & hit0;
   assign ev[1] = fused ? join_hit : hit1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match0 <= 1'b0;
         match1 <= 1'b0;
      end else begin
         match0 <= ev[0];
         match1 <= ev[1];
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_irq
      dtmr_irq_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (ev[g]),
         .clr   (irq_clr[g]),
         .flag  (irq_q[g])
      );
   end

   assign irq0 = irq_q[0];
   assign irq1 = irq_q[1];

endmodule

// File: rtl/dual_interval_timer_chk.sv
`timescale 1ns/1ps
module dual_interval_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       run,
   input logic [1:0] mode,
   input logic [1:0] irq_clr,
   input logic       match0,
   input logic       match1,
   input logic       irq0,
   input logic       irq1
);

   // R7
   run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!match0 && !match1));

   // R6
   fused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match0 |-> ($past(mode) != 2'b01));

   // R8
   irq0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match0 |-> irq0);

   // R8
   irq1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match1 |-> irq1);

   // R8
   irq0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq0 && !irq_clr[0]) |=> irq0);

   // R8
   irq1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq1 && !irq_clr[1]) |=> irq1);

   // R8
   irq1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr[1] |=> (!irq1 || match1));

endmodule

bind dual_interval_timer dual_interval_timer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .mode    (mode),
   .irq_clr (irq_clr),
   .match0  (match0),
   .match1  (match1),
   .irq0    (irq0),
   .irq1    (irq1)
);

// File: tb/dual_interval_timer_bench.sv
`timescale 1ns/1ps
module dual_interval_timer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [1:0] t0_sel = 2'd0;
   logic [1:0] t1_sel = 2'd0;
   logic [2:0] pre_tick = 3'b001;
   logic       ext_tick = 1'b0;
   logic [7:0] cmp0 = 8'd0;
   logic [7:0] cmp1 = 8'd0;
   logic [1:0] irq_clr = 2'b00;
   logic       match0, match1, irq0, irq1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int tdiv   = 0;

   int p0a, p0b, p1a, p1b, n0, n1, seq_bad;

   always #2 clk = ~clk;

   dual_interval_timer u_dual_interval_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .mode     (mode),
      .t0_sel   (t0_sel),
      .t1_sel   (t1_sel),
      .pre_tick (pre_tick),
      .ext_tick (ext_tick),
      .cmp0     (cmp0),
      .cmp1     (cmp1),
      .irq_clr  (irq_clr),
      .match0   (match0),
      .match1   (match1),
      .irq0     (irq0),
      .irq1     (irq1)
   );

   // prescaler strobes: [0] every cycle, [1] every 2nd, [2] every 4th
   initial begin
      forever begin
         @(negedge clk);
         tdiv++;
         pre_tick[1] = (tdiv % 2) == 0;
         pre_tick[2] = (tdiv % 4) == 0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(input int n);
      bit prev0 = 1'b0;
      p0a = 0; p0b = 0; p1a = 0; p1b = 0; n0 = 0; n1 = 0; seq_bad = 0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (match0) begin
            n0++;
            if (p0a == 0) p0a = i; else if (p0b == 0) p0b = i;
         end
         if (match1) begin
            n1++;
            if (p1a == 0) p1a = i; else if (p1b == 0) p1b = i;
            if (!prev0) seq_bad++;
         end
         prev0 = match0;
      end
   endtask

   task automatic halt_and_clear();
      @(negedge clk);
      run = 1'b0;
      irq_clr = 2'b11;
      @(negedge clk);
      irq_clr = 2'b00;
   endtask

   task automatic start();
      @(negedge clk);
      run = 1'b1;
   endtask

   task automatic t_reset();
      check("R10 match0", match0, 0);
      check("R10 match1", match1, 0);
      check("R10 irq0", irq0, 0);
      check("R10 irq1", irq1, 0);
   endtask

   task automatic t_basic();
      halt_and_clear();
      mode = 2'b00; t0_sel = 2'd0; cmp0 = 8'd5; t1_sel = 2'd1; cmp1 = 8'd3;
      start();
      measure(40);
      check("R1 first match0", p0a, 5);
      check("R1 match0 period", p0b - p0a, 5);
      check("R2 timer1 on pre_tick[1] period", p1b - p1a, 6);
      check("R8 irq0 set", irq0, 1);
   endtask

   task automatic t_slow_src();
      halt_and_clear();
      mode = 2'b10; t0_sel = 2'd2; cmp0 = 8'd3; t1_sel = 2'd0; cmp1 = 8'd200;
      start();
      measure(60);
      check("R2 pre_tick[2] period", p0b - p0a, 12);
      check("R5 mode 10 stays 8-bit", n0 > 0, 1);
   endtask

   task automatic t_zero_cmp();
      halt_and_clear();
      mode = 2'b11; t0_sel = 2'd0; cmp0 = 8'd0; t1_sel = 2'd1; cmp1 = 8'd100;
      start();
      measure(520);
      check("R3 first match0", p0a, 256);
      check("R3 period", p0b - p0a, 256);
   endtask

   task automatic t_chain();
      halt_and_clear();
      mode = 2'b00; t0_sel = 2'd0; cmp0 = 8'd5; t1_sel = 2'd3; cmp1 = 8'd2;
      start();
      measure(40);
      check("R4 first match1", p1a, 11);
      check("R4 match1 period", p1b - p1a, 10);
      check("R4 match1 follows match0", seq_bad, 0);
   endtask

   task automatic t_fused();
      halt_and_clear();
      mode = 2'b01; t0_sel = 2'd0; t1_sel = 2'd0;
      cmp1 = 8'h01; cmp0 = 8'h2C;
      start();
      measure(650);
      check("R5 first 16-bit match", p1a, 300);
      check("R5 16-bit period", p1b - p1a, 300);
      check("R6 match0 quiet in 16-bit", n0, 0);
      check("R6 t1_sel ignored (count)", n1, 2);
      check("R8 irq1 set", irq1, 1);
      check("R8 irq0 untouched", irq0, 0);
      @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      check("R8 irq1 held", irq1, 1);
      irq_clr = 2'b10;
      @(negedge clk);
      irq_clr = 2'b00;
      check("R8 irq1 cleared", irq1, 0);
   endtask

   task automatic t_run_gate();
      halt_and_clear();
      mode = 2'b00; t0_sel = 2'd0; cmp0 = 8'd7; t1_sel = 2'd0; cmp1 = 8'd4;
      start();
      measure(17);
      @(negedge clk);
      run = 1'b0;
      measure(10);
      check("R7 no match0 while stopped", n0, 0);
      check("R7 no match1 while stopped", n1, 0);
      start();
      measure(10);
      check("R7 restart from zero t0", p0a, 7);
      check("R7 restart from zero t1", p1a, 4);
   endtask

   task automatic t_cmp_update();
      int gap = 0;
      halt_and_clear();
      mode = 2'b00; t0_sel = 2'd0; cmp0 = 8'd5; t1_sel = 2'd1; cmp1 = 8'd50;
      start();
      for (int i = 0; i < 20 && !match0; i++) @(negedge clk);
      cmp0 = 8'd3;
      for (int i = 1; i <= 20; i++) begin
         @(negedge clk);
         if (match0 && gap == 0) gap = i;
      end
      check("R9 new compare used next", gap, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_slow_src();
      t_zero_cmp();
      t_chain();
      t_fused();
      t_run_gate();
      t_cmp_update();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule